// File: doc/BRIEF.md
# Indexed DMA Channel Address Sequencer

This block sequences the addresses and counts for one DMA channel. After a start strobe it holds a source and a destination address and walks through a block made of frames, each frame made of elements. After every element each address moves by a signed index: an element index inside a frame, and a separate frame index on the frame's last element. Each side has its own one-bit select that picks which index pair it uses.

Two run styles are supported. In multiframe style the channel stops after the last element of the last frame. In circular-buffer style it treats one frame as a ring: it wraps both addresses back to their bases after the last element and keeps running until `run_en` is dropped. A doubleword option moves each element as two 16-bit beats. A sync selector can free-run the channel or pace it one element per rising edge of a chosen serial-port event. Interrupts are single-cycle pulses whose position depends on the enable bit, the interrupt mode and the run style.

The bus side sees a valid/ready pair. `xfer_valid` offers the current beat at `src_addr`/`dst_addr`. A beat moves on a cycle where both `xfer_valid` and `xfer_ready` are high. While `xfer_ready` is low the offer and the addresses hold, so the bus can apply back-pressure for any number of cycles. Configuration inputs must stay static while `busy` is high.

Top module: `dma_chan_seq`

## Requirements
- R1: During and right after reset, `busy`, `xfer_valid`, `beat_hi` and `irq` are 0.
- R2: A `start` pulse with `run_en` high loads `src_addr`/`dst_addr` from their base inputs, clears the element, frame and beat position and sets `busy`. This also applies when the channel is already running.
- R3: When an element completes and it is not the last of its frame, each address adds the element index named by its select: select 0 uses `cfg_idx_elem0` and select 1 uses `cfg_idx_elem1`.
- R4: When the last element of a frame completes in multiframe style, each address instead adds `cfg_idx_frame0` (select 0) or `cfg_idx_frame1` (select 1). All additions are 16-bit two's complement modulo 2^16.
- R5: With `cfg_dbl` set, an element is two beats. On the first beat `beat_hi` is 0 and both addresses step by +1 when it moves. On the second beat `beat_hi` is 1 and the index step of R3/R4 applies. Only the second beat counts toward element and frame counts.
- R6: In multiframe style, `busy` falls and `xfer_valid` drops after (`cfg_elems_m1`+1)·(`cfg_frames_m1`+1) elements.
- R7: In multiframe style with `cfg_int_en`=1, mode 0 pulses `irq` only at block end, and mode 1 pulses it at each frame end, the block end included. The pulse comes in the cycle after the completing beat moves.
- R8: In circular-buffer style (`cfg_abu`=1), after the last of `cfg_elems_m1`+1 elements both addresses return to their bases and counting restarts. `irq` pulses at full when `cfg_int_en`=1. In mode 1 it also pulses at half, that is after element number floor(E/2) completes when E≥2.
- R9: With `cfg_int_en`=0, `irq` stays 0 in every style and mode.
- R10: `cfg_sync_sel`=0 free-runs. Values 1 to 4 select `sync_evt[0]` to `sync_evt[3]`, and values 5 to 15 never trigger. When synchronized, each rising edge of the selected event grants one element (both beats), and an edge arriving while an element is pending or in progress is held as a single pending grant.
- R11: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `src_addr` and `dst_addr` hold. `xfer_ready` without `xfer_valid` changes nothing.
- R12: With `run_en` low, `busy` clears, `beat_hi` returns to 0 and `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Channel enable; low stops the channel |
| start | input | 1 | Start strobe |
| cfg_src_base | input | 16 | Source start address |
| cfg_dst_base | input | 16 | Destination start address |
| cfg_elems_m1 | input | 8 | Elements per frame minus one |
| cfg_frames_m1 | input | 8 | Frames per block minus one |
| cfg_src_sel | input | 1 | Source index pair select |
| cfg_dst_sel | input | 1 | Destination index pair select |
| cfg_idx_elem0 | input | 16 | Element index, set 0 |
| cfg_idx_elem1 | input | 16 | Element index, set 1 |
| cfg_idx_frame0 | input | 16 | Frame index, set 0 |
| cfg_idx_frame1 | input | 16 | Frame index, set 1 |
| cfg_dbl | input | 1 | Doubleword (two-beat) elements |
| cfg_abu | input | 1 | Circular-buffer style |
| cfg_int_en | input | 1 | Interrupt enable |
| cfg_int_mode | input | 1 | Interrupt mode |
| cfg_sync_sel | input | 4 | Sync event select |
| sync_evt | input | 4 | Serial-port events |
| xfer_valid | output | 1 | Beat offered to the bus |
| xfer_ready | input | 1 | Bus accepts the beat |
| src_addr | output | 16 | Current source address |
| dst_addr | output | 16 | Current destination address |
| beat_hi | output | 1 | Second beat of a doubleword element |
| busy | output | 1 | Channel active |
| irq | output | 1 | Interrupt pulse |

## Verification
Several events can land in one cycle. A sync edge can arrive in the same cycle in which the pending grant is consumed by a moving first beat. A `start` or a fall of `run_en` can also coincide with a moving beat. The bench drives `sync_evt`, `xfer_ready` and the beat acceptance from seeded random draws at high rates so these overlaps happen often. A cycle-level reference model built from the requirements predicts, every cycle, whether the next element is granted, which addresses appear, and whether `irq` pulses. Any lost or doubled grant, or an address step applied on a restart, shows up at the ports as a mismatch.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int ADDR_W  = 16;
  localparam int SEL_W   = 4;
  localparam int NUM_EVT = 4;

  typedef enum logic [SEL_W-1:0] {
    SYNC_FREE  = 4'd0,
    SYNC_P0_RX = 4'd1,
    SYNC_P0_TX = 4'd2,
    SYNC_P2_RX = 4'd3,
    SYNC_P2_TX = 4'd4
  } sync_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] elem0;
    logic [ADDR_W-1:0] elem1;
    logic [ADDR_W-1:0] frame0;
    logic [ADDR_W-1:0] frame1;
  } idx_set_t;
endpackage

// File: rtl/dma_evt_gate.sv
module dma_evt_gate #(
  parameter int SEL_W   = 4,
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               clear,
  input  logic               take,
  output logic               free_run,
  output logic               credit
);
  logic evt_bit, evt_prev, edge_hit;

  always_comb begin
    evt_bit = 1'b0;
    for (int k = 0; k < NUM_EVT; k++)
      if (sel == SEL_W'(k + 1)) evt_bit = evt[k];
  end

  assign free_run = (sel == '0);
  assign edge_hit = evt_bit & ~evt_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev <= 1'b0;
      credit   <= 1'b0;
    end else begin
      evt_prev <= evt_bit;
      if (clear) credit <= 1'b0;
      else       credit <= edge_hit | (credit & ~take);
    end
  end
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          half_beat,
  input  logic          wrap,
  input  logic          use_frame,
  input  logic          sel,
  input  idx_set_t      idx,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] step;

  always_comb begin
    if (half_beat)      step = AW'(1);
    else if (use_frame) step = sel ? AW'(idx.frame1) : AW'(idx.frame0);
    else                step = sel ? AW'(idx.elem1)  : AW'(idx.elem0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr <= '0;
    else if (load)             addr <= base;
    else if (adv && wrap && !half_beat) addr <= base;
    else if (adv)              addr <= addr + step;
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CNT_W = 8,
  parameter int SW    = 4,
  parameter int NE    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          start,
  input  logic [AW-1:0] cfg_src_base,
  input  logic [AW-1:0] cfg_dst_base,
  input  logic [CNT_W-1:0] cfg_elems_m1,
  input  logic [CNT_W-1:0] cfg_frames_m1,
  input  logic          cfg_src_sel,
  input  logic          cfg_dst_sel,
  input  logic [AW-1:0] cfg_idx_elem0,
  input  logic [AW-1:0] cfg_idx_elem1,
  input  logic [AW-1:0] cfg_idx_frame0,
  input  logic [AW-1:0] cfg_idx_frame1,
  input  logic          cfg_dbl,
  input  logic          cfg_abu,
  input  logic          cfg_int_en,
  input  logic          cfg_int_mode,
  input  logic [SW-1:0] cfg_sync_sel,
  input  logic [NE-1:0] sync_evt,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          beat_hi,
  output logic          busy,
  output logic          irq
);
  localparam int HW = CNT_W + 1;

  logic [CNT_W-1:0] elem_q, frame_q;
  logic             free_run, credit;
  logic             load, fire, adv, elem_done, half_beat;
  logic             last_in_frame, last_frame, half_hit, irq_d;
  logic [HW-1:0]    half_pt;
  idx_set_t         idx;

  assign load      = start & run_en;
  assign fire      = xfer_valid & xfer_ready;
  assign adv       = fire & run_en & ~start;
  assign half_beat = cfg_dbl & ~beat_hi;
  assign elem_done = adv & ~half_beat;

  assign last_in_frame = (elem_q == cfg_elems_m1);
  assign last_frame    = (frame_q == cfg_frames_m1);
  assign half_pt       = ({1'b0, cfg_elems_m1} + HW'(1)) >> 1;
  assign half_hit      = (half_pt != '0) && (({1'b0, elem_q} + HW'(1)) == half_pt);

  assign xfer_valid = busy & (free_run | credit | beat_hi);

  assign idx = '{elem0: cfg_idx_elem0, elem1: cfg_idx_elem1,
                 frame0: cfg_idx_frame0, frame1: cfg_idx_frame1};

  dma_evt_gate #(.SEL_W(SW), .NUM_EVT(NE)) u_gate (
    .clk(clk), .rst_n(rst_n), .sel(cfg_sync_sel), .evt(sync_evt),
    .clear(load), .take(adv & ~beat_hi),
    .free_run(free_run), .credit(credit)
  );

  logic [1:0][AW-1:0] base_a, addr_a;
  logic [1:0]         sel_a;
  assign base_a = {cfg_dst_base, cfg_src_base};
  assign sel_a  = {cfg_dst_sel, cfg_src_sel};

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_addr_unit #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(load), .base(base_a[s]),
      .adv(adv), .half_beat(half_beat), .wrap(cfg_abu & last_in_frame),
      .use_frame(last_in_frame), .sel(sel_a[s]), .idx(idx),
      .addr(addr_a[s])
    );
  end

  assign src_addr = addr_a[0];
  assign dst_addr = addr_a[1];

  always_comb begin
    irq_d = 1'b0;
    if (cfg_int_en && elem_done) begin
      if (cfg_abu) irq_d = last_in_frame | (cfg_int_mode & half_hit);
      else         irq_d = last_in_frame & (last_frame | cfg_int_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      beat_hi <= 1'b0;
      elem_q  <= '0;
      frame_q <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= irq_d;
      if (!run_en) begin
        busy    <= 1'b0;
        beat_hi <= 1'b0;
      end else if (start) begin
        busy    <= 1'b1;
        beat_hi <= 1'b0;
        elem_q  <= '0;
        frame_q <= '0;
      end else if (adv) begin
        beat_hi <= half_beat;
        if (elem_done) begin
          if (!last_in_frame) elem_q <= elem_q + CNT_W'(1);
          else begin
            elem_q <= '0;
            if (!cfg_abu) begin
              if (last_frame) begin
                busy    <= 1'b0;
                frame_q <= '0;
              end else frame_q <= frame_q + CNT_W'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          start,
  input logic          cfg_dbl,
  input logic          cfg_int_en,
  input logic          xfer_valid,
  input logic          xfer_ready,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic          beat_hi,
  input logic          busy,
  input logic          irq
);
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready && run_en && !start) |=>
      (xfer_valid && $stable(src_addr) && $stable(dst_addr))); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !xfer_valid); // R6

  AST_IRQ_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(xfer_valid && xfer_ready)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_int_en) |-> !irq); // R9

  AST_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && !beat_hi && cfg_dbl && run_en && !start) |=> beat_hi); // R5

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!busy && !beat_hi)); // R12
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .start(start),
  .cfg_dbl(cfg_dbl), .cfg_int_en(cfg_int_en),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
  .src_addr(src_addr), .dst_addr(dst_addr),
  .beat_hi(beat_hi), .busy(busy), .irq(irq)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_en, start, xfer_ready;
  logic [15:0] src_base, dst_base, ie0, ie1, if0, if1;
  logic [7:0]  elems_m1, frames_m1;
  logic ssel, dsel, dbl, abu, int_en, int_mode;
  logic [3:0] sync_sel, evt;
  logic xfer_valid, beat_hi, busy, irq;
  logic [15:0] src_addr, dst_addr;

  int checks = 0, errors = 0;
  logic m_busy, m_beat, m_credit, m_prev, m_irq;
  logic [15:0] m_src, m_dst;
  logic [7:0]  m_elem, m_frame;

  always #10 clk = ~clk;

  dma_chan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .start(start),
    .cfg_src_base(src_base), .cfg_dst_base(dst_base),
    .cfg_elems_m1(elems_m1), .cfg_frames_m1(frames_m1),
    .cfg_src_sel(ssel), .cfg_dst_sel(dsel),
    .cfg_idx_elem0(ie0), .cfg_idx_elem1(ie1),
    .cfg_idx_frame0(if0), .cfg_idx_frame1(if1),
    .cfg_dbl(dbl), .cfg_abu(abu), .cfg_int_en(int_en), .cfg_int_mode(int_mode),
    .cfg_sync_sel(sync_sel), .sync_evt(evt),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .beat_hi(beat_hi), .busy(busy), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] step_of(input logic s, input logic fr);
    if (fr) return s ? if1 : if0;
    return s ? ie1 : ie0;
  endfunction

  function automatic logic exp_valid();
    return m_busy && (sync_sel == 4'd0 || m_credit || m_beat);
  endfunction

  // reference model of one clock edge, from the requirements
  task automatic model_step();
    logic fire, adv, ebit, edge_hit, last_in, hh;
    logic [8:0] hp;
    fire = exp_valid() && xfer_ready;
    adv  = fire && run_en && !start;
    ebit = (sync_sel >= 4'd1 && sync_sel <= 4'd4) ? evt[sync_sel - 4'd1] : 1'b0;
    edge_hit = ebit && !m_prev;
    m_prev = ebit;
    m_credit = (start && run_en) ? 1'b0 : (edge_hit || (m_credit && !(adv && !m_beat)));
    m_irq = 1'b0;
    last_in = (m_elem == elems_m1);
    hp = ({1'b0, elems_m1} + 9'd1) >> 1;
    hh = (hp != 0) && ({1'b0, m_elem} + 9'd1 == hp);
    if (!run_en) begin
      m_busy = 0; m_beat = 0;
    end else if (start) begin
      m_busy = 1; m_beat = 0; m_elem = 0; m_frame = 0;
      m_src = src_base; m_dst = dst_base;
    end else if (adv) begin
      if (dbl && !m_beat) begin
        m_beat = 1; m_src += 16'd1; m_dst += 16'd1;
      end else begin
        m_beat = 0;
        if (abu) begin
          if (last_in) begin
            m_src = src_base; m_dst = dst_base; m_elem = 0; m_irq = int_en;
          end else begin
            m_src += step_of(ssel, 0); m_dst += step_of(dsel, 0); m_elem++;
            m_irq = int_en && int_mode && hh;
          end
        end else if (last_in) begin
          m_src += step_of(ssel, 1); m_dst += step_of(dsel, 1); m_elem = 0;
          if (m_frame == frames_m1) begin
            m_busy = 0; m_frame = 0; m_irq = int_en;
          end else begin
            m_frame++; m_irq = int_en && int_mode;
          end
        end else begin
          m_src += step_of(ssel, 0); m_dst += step_of(dsel, 0); m_elem++;
        end
      end
    end
  endtask

  task automatic compare();
    chk(xfer_valid, exp_valid(), "R10 R11 valid");
    chk(busy, m_busy, "R6 R12 busy");
    chk(beat_hi, m_beat, "R5 beat");
    chk(irq, m_irq, "R7 R8 R9 irq");
    if (m_busy) begin
      chk(src_addr, m_src, "R3 R4 R5 R8 src");
      chk(dst_addr, m_dst, "R3 R4 R5 R8 dst");
    end
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    compare();
    start = 1'b0;
  endtask

  task automatic rand_cfg(input int r);
    src_base = 16'($urandom); dst_base = 16'($urandom);
    ie0 = 16'($urandom); ie1 = 16'($urandom % 8);
    if0 = 16'($urandom); if1 = 16'hFFF0 + 16'($urandom % 16);
    elems_m1 = 8'($urandom % 6); frames_m1 = 8'($urandom % 4);
    ssel = 1'($urandom); dsel = 1'($urandom);
    dbl = 1'($urandom); abu = (r % 3 == 2); int_en = (r % 5 != 4);
    int_mode = 1'($urandom);
    case ($urandom % 6)
      0, 1: sync_sel = 4'd0;
      5:    sync_sel = 4'd9;
      default: sync_sel = 4'($urandom % 4 + 1);
    endcase
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    run_en = 1; start = 0; xfer_ready = 0; evt = 0;
    src_base = 0; dst_base = 0; ie0 = 0; ie1 = 0; if0 = 0; if1 = 0;
    elems_m1 = 0; frames_m1 = 0; ssel = 0; dsel = 0;
    dbl = 0; abu = 0; int_en = 0; int_mode = 0; sync_sel = 0;
    m_busy = 0; m_beat = 0; m_credit = 0; m_prev = 0; m_irq = 0;
    m_src = 0; m_dst = 0; m_elem = 0; m_frame = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy, 0, "R1 busy"); chk(xfer_valid, 0, "R1 valid");
    chk(beat_hi, 0, "R1 beat"); chk(irq, 0, "R1 irq");
    rst_n = 1;
    @(negedge clk);
    compare();

    // directed: two elements, one frame, frame index wraps modulo 2^16
    src_base = 16'h0010; dst_base = 16'h0100; ie0 = 16'd3; if0 = 16'hFFF0;
    elems_m1 = 1; frames_m1 = 0; int_en = 1; int_mode = 0;
    start = 1; step();
    chk(src_addr, 16'h0010, "R2 src base"); chk(dst_addr, 16'h0100, "R2 dst base");
    xfer_ready = 1; step();
    chk(src_addr, 16'h0013, "R3 element step");
    step();
    chk(busy, 0, "R6 done"); chk(irq, 1, "R7 block irq");
    chk(src_addr, 16'h0003, "R4 frame step wrap");
    xfer_ready = 0;

    // directed: reserved sync select never triggers
    sync_sel = 4'd9; start = 1; step();
    for (int i = 0; i < 8; i++) begin
      evt = 4'($urandom); xfer_ready = 1; step();
      chk(xfer_valid, 0, "R10 reserved select");
    end
    // directed: run_en low blocks start
    sync_sel = 0; run_en = 0; start = 1; step();
    chk(busy, 0, "R12 start ignored");
    run_en = 1;

    // directed: circular buffer, E=2, half and full
    elems_m1 = 1; abu = 1; int_en = 1; int_mode = 1; dbl = 0; xfer_ready = 0;
    start = 1; step();
    xfer_ready = 1; step(); chk(irq, 1, "R8 half irq");
    step(); chk(irq, 1, "R8 full irq"); chk(src_addr, 16'h0010, "R8 wrap");
    run_en = 0; xfer_ready = 0; step(); run_en = 1; abu = 0;

    for (int r = 0; r < 60; r++) begin
      rand_cfg(r);
      start = 1; step();
      for (int c = 0; c < 300; c++) begin
        xfer_ready = ($urandom % 10) < 7;
        if ($urandom % 3 == 0) evt = 4'($urandom);
        if (abu && c == 200) run_en = 0;
        if (c == 205) run_en = 1;
        if (c == 150 && r % 7 == 3) start = 1;
        step();
        if (!abu && !m_busy && c > 10) break;
      end
      run_en = 1; xfer_ready = 0; step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule